// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic core for a pair of 8-bit accumulators, A and B. Read together, they form a 16-bit double accumulator D, with A as the high byte and B as the low byte. The block keeps A, B and a five-bit flag register. Each operation it is given updates some of that state.

The surrounding pipeline does the decoding and the memory fetch. It presents an operation code, an accumulator select and a 16-bit operand, then raises `start` for one cycle.

Most operations finish on the clock edge that accepts them. The unsigned 8×8 multiply is different: it runs a shift-and-add sequencer that keeps the unit busy for ten cycles in all.

The controller has three states:

- **IDLE**: waits for `start`. An accepted multiply loads the sequencer and moves to **MUL_STEP**. Every other accepted code is applied at once and the state stays in IDLE.
- **MUL_STEP**: one partial-product step each cycle. After the last step it moves to **MUL_WRITE**.
- **MUL_WRITE**: writes the product into D and the carry flag, then returns to IDLE.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i` are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 bit test, 7 OR, 8 XOR, 9 load, 10 store, 11 clear, 12 complement, 13 negate, 14 increment, 15 decrement, 16 test, 17 arithmetic left shift, 18 arithmetic right shift, 19 logical right shift, 20 rotate left, 21 rotate right, 22 D add, 23 D subtract, 24 D left shift, 25 D logical right shift, 26 decimal adjust, 27 multiply.
  - `ccr_o` is packed {H,N,Z,V,C} with C in bit 0.
  - `sel_b_i`=1 makes B the 8-bit target, and the 8-bit operand is `operand_i[7:0]`.
  - A `start_i` accepted while idle takes effect on that edge, and `done_o` is high in the following cycle.
- R2: Add and add-with-carry (carry-in C) write the sum. H is the carry out of bit 3, C is the carry out of bit 7, and V is set when both inputs share a sign that the result does not have.
- R3: Subtract, subtract-with-borrow (borrow-in C) and compare form target−operand. C is set when a borrow occurs, V flags signed overflow, H is unchanged, and compare writes no accumulator.
- R4: AND, bit test, OR, XOR, load and store set N and Z from their result, clear V and keep C. Bit test and store write no accumulator; store takes its flags from the accumulator itself.
- R5: Clear writes zero with N=0, Z=1, V=0, C=0. Complement inverts the target, sets N and Z, clears V and sets C.
- R6: Negate writes 0−target, sets C unless the target was 0 and sets V only for 0x80. Test leaves the target, sets N and Z and clears V and C.
- R7: Increment and decrement keep C. V is set only when increment starts at 0x7F or decrement starts at 0x80.
- R8: The 8-bit shifts and rotates put the bit shifted out into C, and rotates take the old C into the vacated end. V = N XOR C afterwards, and the logical right shift always clears N.
- R9: D add and D subtract use `operand_i[15:8]` as the high byte and `operand_i[7:0]` as the low byte. They set N, Z, V and C over 16 bits, with C meaning borrow for subtract.
- R10: The D left shift moves B bit 7 into A bit 0 and A bit 7 into C. The D logical right shift moves A bit 0 into B bit 7 and B bit 0 into C. Both give V = N XOR C.
- R11: Decimal adjust always works on A, whatever `sel_b_i` says.
  - It adds 0x06 when H is set or the low digit exceeds 9.
  - It adds 0x60, and sets C, when C was set, the high digit exceeds 9, or the high digit exceeds 8 while the low digit exceeds 9. Otherwise C is cleared.
  - It sets N and Z from the result and clears V.
- R12: Multiply writes A×B into D exactly ten cycles after acceptance, with `busy_o` high for the nine cycles between. It sets C to bit 7 of the product, changes no other flag, and ignores `start_i` while busy.
- R13: Only add and add-with-carry change H. Codes 28 to 31 change no state and produce no `done_o`.
- R14: After reset A, B and all flags are zero, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one operation (sampled when idle) |
| op_i | input | 5 | Operation code |
| sel_b_i | input | 1 | 8-bit target select: 0 = A, 1 = B |
| operand_i | input | 16 | Memory operand; low byte for 8-bit operations |
| acc_a_o | output | 8 | Accumulator A (high byte of D) |
| acc_b_o | output | 8 | Accumulator B (low byte of D) |
| ccr_o | output | 5 | Flags {H,N,Z,V,C} |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | An operation completed on the previous edge |

## Verification
The bench goes after the flag edges where signed overflow occurs: 0x7F plus one, increment of 0x7F, decrement and negate of 0x80. A design that took V from the carry chain would flip V there.

It checks decimal adjust on a sum that needs only the low correction and on 0x9A, which must wrap to zero with C set. A design that ignored H or the 9-over-9 rule would leave binary digits behind.

It checks the D shifts on patterns where A bit 0 and B bit 7 differ. A design that dropped the crossing bit would corrupt one byte of D.

During a multiply it injects a clear request and compares every clock. A design that accepted it, took a cycle too many or too few, or disturbed N, Z, V or H would mismatch on a specific cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int ACC_W  = 8;
    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_BIT  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_LOAD = 5'd9,
        OP_STOR = 5'd10,
        OP_CLR  = 5'd11,
        OP_COM  = 5'd12,
        OP_NEG  = 5'd13,
        OP_INC  = 5'd14,
        OP_DEC  = 5'd15,
        OP_TST  = 5'd16,
        OP_ASL  = 5'd17,
        OP_ASR  = 5'd18,
        OP_LSR  = 5'd19,
        OP_ROL  = 5'd20,
        OP_ROR  = 5'd21,
        OP_ADDW = 5'd22,
        OP_SUBW = 5'd23,
        OP_ASLW = 5'd24,
        OP_LSRW = 5'd25,
        OP_DAJ  = 5'd26,
        OP_MUL  = 5'd27
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_MUL_STEP  = 2'd1,
        ST_MUL_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/acc_alu_unit8.sv
module acc_alu_unit8
    import acc_alu_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   mem,
    input  flags_t         fin,
    output logic [W-1:0]   res,
    output flags_t         fout,
    output logic           wr_acc,
    output logic           hit
);

    localparam int HW = W / 2;
    localparam logic [W-1:0] SIGN_ONLY = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS   = ~SIGN_ONLY;
    localparam logic [HW-1:0] NINE     = HW'(9);
    localparam logic [HW-1:0] EIGHT    = HW'(8);
    localparam logic [HW-1:0] SIX      = HW'(6);

    logic          cin;
    logic [W:0]    sum;
    logic [W:0]    diff;
    logic [HW:0]   half;
    logic [W-1:0]  r;
    logic          set_nz;
    logic          shift_v;
    logic          adj_lo;
    logic          adj_hi;

    assign cin  = fin.c & ((op == OP_ADC) | (op == OP_SBC));
    assign sum  = {1'b0, acc} + {1'b0, mem} + {{W{1'b0}}, cin};
    assign diff = {1'b0, acc} - {1'b0, mem} - {{W{1'b0}}, cin};
    assign half = {1'b0, acc[HW-1:0]} + {1'b0, mem[HW-1:0]} + {{HW{1'b0}}, cin};

    assign adj_lo = fin.h | (acc[HW-1:0] > NINE);
    assign adj_hi = fin.c | (acc[W-1:HW] > NINE) |
                    ((acc[W-1:HW] > EIGHT) & (acc[HW-1:0] > NINE));

    always_comb begin
        r       = acc;
        fout    = fin;
        wr_acc  = 1'b0;
        hit     = 1'b1;
        set_nz  = 1'b1;
        shift_v = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                r      = sum[W-1:0];
                fout.h = half[HW];
                fout.c = sum[W];
                fout.v = (acc[W-1] == mem[W-1]) & (r[W-1] != acc[W-1]);
                wr_acc = 1'b1;
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                r      = diff[W-1:0];
                fout.c = diff[W];
                fout.v = (acc[W-1] != mem[W-1]) & (r[W-1] != acc[W-1]);
                wr_acc = (op != OP_CMP);
            end
            OP_AND, OP_BIT: begin
                r      = acc & mem;
                fout.v = 1'b0;
                wr_acc = (op == OP_AND);
            end
            OP_OR: begin
                r      = acc | mem;
                fout.v = 1'b0;
                wr_acc = 1'b1;
            end
            OP_XOR: begin
                r      = acc ^ mem;
                fout.v = 1'b0;
                wr_acc = 1'b1;
            end
            OP_LOAD: begin
                r      = mem;
                fout.v = 1'b0;
                wr_acc = 1'b1;
            end
            OP_STOR: begin
                r      = acc;
                fout.v = 1'b0;
            end
            OP_CLR: begin
                r      = '0;
                fout.v = 1'b0;
                fout.c = 1'b0;
                wr_acc = 1'b1;
            end
            OP_COM: begin
                r      = ~acc;
                fout.v = 1'b0;
                fout.c = 1'b1;
                wr_acc = 1'b1;
            end
            OP_NEG: begin
                r      = '0 - acc;
                fout.c = (acc != '0);
                fout.v = (acc == SIGN_ONLY);
                wr_acc = 1'b1;
            end
            OP_INC: begin
                r      = acc + 1'b1;
                fout.v = (acc == MAX_POS);
                wr_acc = 1'b1;
            end
            OP_DEC: begin
                r      = acc - 1'b1;
                fout.v = (acc == SIGN_ONLY);
                wr_acc = 1'b1;
            end
            OP_TST: begin
                r      = acc;
                fout.v = 1'b0;
                fout.c = 1'b0;
            end
            OP_ASL: begin
                r       = {acc[W-2:0], 1'b0};
                fout.c  = acc[W-1];
                shift_v = 1'b1;
                wr_acc  = 1'b1;
            end
            OP_ROL: begin
                r       = {acc[W-2:0], fin.c};
                fout.c  = acc[W-1];
                shift_v = 1'b1;
                wr_acc  = 1'b1;
            end
            OP_ASR: begin
                r       = {acc[W-1], acc[W-1:1]};
                fout.c  = acc[0];
                shift_v = 1'b1;
                wr_acc  = 1'b1;
            end
            OP_LSR: begin
                r       = {1'b0, acc[W-1:1]};
                fout.c  = acc[0];
                shift_v = 1'b1;
                wr_acc  = 1'b1;
            end
            OP_ROR: begin
                r       = {fin.c, acc[W-1:1]};
                fout.c  = acc[0];
                shift_v = 1'b1;
                wr_acc  = 1'b1;
            end
            OP_DAJ: begin
                r      = acc + {(adj_hi ? SIX : '0), (adj_lo ? SIX : '0)};
                fout.c = adj_hi;
                fout.v = 1'b0;
                wr_acc = 1'b1;
            end
            default: begin
                hit    = 1'b0;
                set_nz = 1'b0;
            end
        endcase
        if (set_nz) begin
            fout.n = r[W-1];
            fout.z = (r == '0);
        end
        if (shift_v) begin
            fout.v = fout.n ^ fout.c;
        end
        res = r;
    end

endmodule

// File: rtl/acc_alu_unit16.sv
module acc_alu_unit16
    import acc_alu_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  alu_op_e          op,
    input  logic [2*W-1:0]   d,
    input  logic [2*W-1:0]   mem,
    input  flags_t           fin,
    output logic [2*W-1:0]   res,
    output flags_t           fout,
    output logic             hit
);

    localparam int DW = 2 * W;

    logic [DW:0]   sum;
    logic [DW:0]   diff;
    logic [DW-1:0] r;
    logic          shift_v;

    assign sum  = {1'b0, d} + {1'b0, mem};
    assign diff = {1'b0, d} - {1'b0, mem};

    always_comb begin
        r       = d;
        fout    = fin;
        hit     = 1'b1;
        shift_v = 1'b0;
        unique case (op)
            OP_ADDW: begin
                r      = sum[DW-1:0];
                fout.c = sum[DW];
                fout.v = (d[DW-1] == mem[DW-1]) & (r[DW-1] != d[DW-1]);
            end
            OP_SUBW: begin
                r      = diff[DW-1:0];
                fout.c = diff[DW];
                fout.v = (d[DW-1] != mem[DW-1]) & (r[DW-1] != d[DW-1]);
            end
            OP_ASLW: begin
                r       = {d[DW-2:0], 1'b0};
                fout.c  = d[DW-1];
                shift_v = 1'b1;
            end
            OP_LSRW: begin
                r       = {1'b0, d[DW-1:1]};
                fout.c  = d[0];
                shift_v = 1'b1;
            end
            default: hit = 1'b0;
        endcase
        if (hit) begin
            fout.n = r[DW-1];
            fout.z = (r == '0);
        end
        if (shift_v) begin
            fout.v = fout.n ^ fout.c;
        end
        res = r;
    end

endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [W-1:0]     mcand,
    input  logic [W-1:0]     mplier,
    output logic [2*W-1:0]   prod
);

    logic [W-1:0]   mc_q;
    logic [2*W-1:0] p_q;
    logic [W:0]     partial;

    assign partial = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, mc_q} : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_q <= '0;
            p_q  <= '0;
        end else if (load) begin
            mc_q <= mcand;
            p_q  <= {{W{1'b0}}, mplier};
        end else if (step) begin
            p_q  <= {partial, p_q[W-1:1]};
        end
    end

    assign prod = p_q;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W         = ACC_W,
    parameter int MUL_STEPS = ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              sel_b_i,
    input  logic [2*W-1:0]    operand_i,
    output logic [W-1:0]      acc_a_o,
    output logic [W-1:0]      acc_b_o,
    output logic [FLAG_W-1:0] ccr_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CW = (MUL_STEPS > 1) ? $clog2(MUL_STEPS) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(MUL_STEPS - 1);

    seq_state_e     state_q, state_d;
    alu_op_e        opc;
    logic           accept;
    logic [W-1:0]   a_q, b_q;
    flags_t         fl_q;
    logic           done_q;
    logic [CW-1:0]  cnt_q;

    logic [W-1:0]   src8;
    logic [W-1:0]   r8;
    flags_t         f8;
    logic           wr8, hit8;
    logic [2*W-1:0] r16;
    flags_t         f16;
    logic           hit16;
    logic           mul_load, mul_step;
    logic [2*W-1:0] prod;

    assign opc    = alu_op_e'(op_i);
    assign accept = start_i & (state_q == ST_IDLE);
    assign src8   = (opc == OP_DAJ) ? a_q : (sel_b_i ? b_q : a_q);

    acc_alu_unit8 #(.W(W)) u_unit8 (
        .op     (opc),
        .acc    (src8),
        .mem    (operand_i[W-1:0]),
        .fin    (fl_q),
        .res    (r8),
        .fout   (f8),
        .wr_acc (wr8),
        .hit    (hit8)
    );

    acc_alu_unit16 #(.W(W)) u_unit16 (
        .op   (opc),
        .d    ({a_q, b_q}),
        .mem  (operand_i),
        .fin  (fl_q),
        .res  (r16),
        .fout (f16),
        .hit  (hit16)
    );

    assign mul_load = accept & (opc == OP_MUL);
    assign mul_step = (state_q == ST_MUL_STEP);

    acc_alu_mul #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mul_load),
        .step   (mul_step),
        .mcand  (a_q),
        .mplier (b_q),
        .prod   (prod)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (mul_load) state_d = ST_MUL_STEP;
            ST_MUL_STEP:  if (cnt_q == LAST_STEP) state_d = ST_MUL_WRITE;
            ST_MUL_WRITE: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mul_load) begin
            cnt_q <= '0;
        end else if (mul_step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs and architectural state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            fl_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && hit8) begin
                        fl_q   <= f8;
                        done_q <= 1'b1;
                        if (wr8) begin
                            if ((opc == OP_DAJ) || !sel_b_i) a_q <= r8;
                            else                             b_q <= r8;
                        end
                    end else if (accept && hit16) begin
                        fl_q   <= f16;
                        done_q <= 1'b1;
                        {a_q, b_q} <= r16;
                    end
                end
                ST_MUL_WRITE: begin
                    {a_q, b_q} <= prod;
                    fl_q.c     <= prod[W-1];
                    done_q     <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign acc_a_o = a_q;
    assign acc_b_o = b_q;
    assign ccr_o   = fl_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int MUL_STEPS = ACC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [OP_W-1:0]   op_i,
    input logic [FLAG_W-1:0] ccr_o,
    input logic              busy_o,
    input logic              done_o
);

    logic [7:0] busy_run;
    logic       take;

    assign take = start_i & ~busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 1'b1;
        else             busy_run <= '0;
    end

    a_r12_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_run == 8'(MUL_STEPS)) |=> !busy_o);

    a_r12_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_run <= 8'(MUL_STEPS)));

    a_r12_only_c: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ccr_o[4:1]));

    a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r13_h_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i != OP_ADD && op_i != OP_ADC) |=> $stable(ccr_o[4]));

    a_r5_clr_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i == OP_CLR) |=> (ccr_o[3:0] == 4'b0100));

    a_r5_com_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i == OP_COM) |=> (ccr_o[0] && !ccr_o[1]));

    a_r4_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (op_i == OP_AND || op_i == OP_BIT || op_i == OP_OR ||
                  op_i == OP_XOR || op_i == OP_LOAD || op_i == OP_STOR))
        |=> ($stable(ccr_o[0]) && !ccr_o[1]));

    a_r7_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(ccr_o[0]));

    a_r8_lsr_n: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (op_i == OP_LSR || op_i == OP_LSRW)) |=> !ccr_o[3]);

    a_r6_tst_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_i == OP_TST) |=> (!ccr_o[1] && !ccr_o[0]));

endmodule

bind acc_alu acc_alu_chk #(.MUL_STEPS(MUL_STEPS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .ccr_o   (ccr_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic        sel_b_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic [7:0]  acc_a_o, acc_b_o;
    logic [4:0]  ccr_o;
    logic        busy_o, done_o;

    int compared = 0;
    int mismatched = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    string cmp_req = "R14";

    int exp_a = 0, exp_b = 0;
    logic [4:0] exp_ccr = '0;
    bit exp_busy = 1'b0, exp_done = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .sel_b_i   (sel_b_i),
        .operand_i (operand_i),
        .acc_a_o   (acc_a_o),
        .acc_b_o   (acc_b_o),
        .ccr_o     (ccr_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    // per-clock comparison against the reference model
    always @(posedge clk) begin
        #2;
        if (cmp_en && !finished) begin
            compared++;
            if (acc_a_o !== 8'(exp_a) || acc_b_o !== 8'(exp_b) ||
                ccr_o !== exp_ccr || busy_o !== exp_busy) begin
                mismatched++;
                $display("FAIL %s: a=%h b=%h ccr=%b busy=%b expected a=%h b=%h ccr=%b busy=%b",
                         cmp_req, acc_a_o, acc_b_o, ccr_o, busy_o,
                         8'(exp_a), 8'(exp_b), exp_ccr, exp_busy);
            end
            compared++;
            if (done_o !== exp_done) begin
                mismatched++;
                $display("FAIL R1 (%s) done: actual %b expected %b", cmp_req, done_o, exp_done);
            end
        end
    end

    function automatic string req_of(input int op);
        if (op <= 1)  return "R2";
        if (op <= 4)  return "R3";
        if (op <= 10) return "R4";
        if (op <= 12) return "R5";
        if (op == 13 || op == 16) return "R6";
        if (op <= 15) return "R7";
        if (op <= 21) return "R8";
        if (op <= 23) return "R9";
        if (op <= 25) return "R10";
        if (op == 26) return "R11";
        if (op == 27) return "R12";
        return "R13";
    endfunction

    // behavioural model of one non-multiply operation
    task automatic model_op(input int op, input bit selb, input int m, output bit hit);
        bit h, n, z, v, c, wr, w16, shv;
        int x, mv, r, cin, corr;
        {h, n, z, v, c} = exp_ccr;
        x   = (op == 26) ? exp_a : (selb ? exp_b : exp_a);
        mv  = m & 255;
        r   = x;
        wr  = 1'b0;
        w16 = 1'b0;
        shv = 1'b0;
        hit = 1'b1;
        cin = (op == 1 || op == 3) ? int'(c) : 0;
        case (op)
            0, 1: begin
                r = x + mv + cin;
                h = ((x & 15) + (mv & 15) + cin) > 15;
                c = r > 255; r = r & 255;
                v = (((x ^ mv) & 128) == 0) && (((x ^ r) & 128) != 0);
                wr = 1;
            end
            2, 3, 4: begin
                r = x - mv - cin;
                c = r < 0; r = r & 255;
                v = (((x ^ mv) & 128) != 0) && (((x ^ r) & 128) != 0);
                wr = (op != 4);
            end
            5, 6: begin r = x & mv; v = 0; wr = (op == 5); end
            7:    begin r = x | mv; v = 0; wr = 1; end
            8:    begin r = x ^ mv; v = 0; wr = 1; end
            9:    begin r = mv; v = 0; wr = 1; end
            10:   begin r = x; v = 0; end
            11:   begin r = 0; v = 0; c = 0; wr = 1; end
            12:   begin r = 255 - x; v = 0; c = 1; wr = 1; end
            13:   begin r = (256 - x) & 255; c = (x != 0); v = (x == 128); wr = 1; end
            14:   begin r = (x + 1) & 255; v = (x == 127); wr = 1; end
            15:   begin r = (x + 255) & 255; v = (x == 128); wr = 1; end
            16:   begin r = x; v = 0; c = 0; end
            17:   begin c = x >= 128; r = (x * 2) & 255; shv = 1; wr = 1; end
            20:   begin r = ((x * 2) & 255) + int'(c); c = x >= 128; shv = 1; wr = 1; end
            18:   begin c = x % 2; r = (x / 2) + (x & 128); shv = 1; wr = 1; end
            19:   begin c = x % 2; r = x / 2; shv = 1; wr = 1; end
            21:   begin r = (x / 2) + (c ? 128 : 0); c = x % 2; shv = 1; wr = 1; end
            22, 23, 24, 25: begin
                x = exp_a * 256 + exp_b;
                w16 = 1; wr = 1;
                if (op == 22) begin
                    r = x + m; c = r > 65535; r = r & 65535;
                    v = (((x ^ m) & 32768) == 0) && (((x ^ r) & 32768) != 0);
                end else if (op == 23) begin
                    r = x - m; c = r < 0; r = r & 65535;
                    v = (((x ^ m) & 32768) != 0) && (((x ^ r) & 32768) != 0);
                end else if (op == 24) begin
                    c = x >= 32768; r = (x * 2) & 65535; shv = 1;
                end else begin
                    c = x % 2; r = x / 2; shv = 1;
                end
            end
            26: begin
                corr = 0;
                if (h || (x % 16) > 9) corr += 6;
                if (c || (x / 16) > 9 || ((x / 16) > 8 && (x % 16) > 9)) begin
                    corr += 96; c = 1;
                end else begin
                    c = 0;
                end
                r = (x + corr) & 255; v = 0; wr = 1;
            end
            default: hit = 0;
        endcase
        if (hit) begin
            n = w16 ? (r >= 32768) : (r >= 128);
            z = (r == 0);
            if (shv) v = n ^ c;
            exp_ccr = {h, n, z, v, c};
            if (wr) begin
                if (w16) begin exp_a = r / 256; exp_b = r % 256; end
                else if (op == 26 || !selb) exp_a = r;
                else exp_b = r;
            end
        end
    endtask

    task automatic do_op(input int op, input bit selb, input int m);
        bit hit;
        int pr;
        @(negedge clk);
        start_i = 1; op_i = 5'(op); sel_b_i = selb; operand_i = 16'(m);
        cmp_req = req_of(op);
        if (op == 27) begin
            pr = exp_a * exp_b;
            exp_busy = 1; exp_done = 0;
            for (int k = 1; k <= 9; k++) begin
                @(negedge clk);
                start_i = 0;
                if (k == 3) begin start_i = 1; op_i = 5'd11; end  // R12: ignored while busy
                if (k == 9) begin
                    exp_a = pr / 256; exp_b = pr % 256;
                    exp_ccr[0] = (pr / 128) % 2;
                    exp_busy = 0; exp_done = 1;
                end
            end
        end else begin
            model_op(op, selb, m, hit);
            exp_done = hit;
        end
        @(negedge clk);
        start_i = 0;
        exp_done = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_req = "R14";
        cmp_en = 1;
        @(negedge clk);
        // R2: overflow into sign, half carry
        do_op(9, 0, 8'h7F);  do_op(0, 0, 1);
        do_op(9, 1, 8'h0F);  do_op(0, 1, 8'h01); do_op(1, 1, 8'hF0);
        // R3: borrow and compare
        do_op(2, 0, 8'h90);  do_op(3, 0, 8'h01); do_op(4, 1, 8'hFF);
        // R4: logic family
        do_op(5, 0, 8'hF0); do_op(6, 1, 8'h00); do_op(7, 1, 8'h80);
        do_op(8, 0, 8'hFF); do_op(10, 1, 0);
        // R5, R6, R7
        do_op(11, 1, 0); do_op(12, 1, 0);
        do_op(9, 0, 8'h80); do_op(13, 0, 0); do_op(11, 0, 0); do_op(13, 0, 0);
        do_op(9, 0, 8'h7F); do_op(14, 0, 0); do_op(15, 0, 0); do_op(16, 0, 0);
        do_op(9, 0, 8'h80); do_op(15, 0, 0);
        // R8 shifts and rotates
        do_op(9, 0, 8'h81); do_op(17, 0, 0); do_op(20, 0, 0); do_op(18, 0, 0);
        do_op(19, 0, 0); do_op(21, 0, 0); do_op(19, 1, 0);
        // R9, R10 double accumulator
        do_op(9, 0, 8'h7F); do_op(9, 1, 8'hF0);
        do_op(22, 0, 16'h1234); do_op(23, 0, 16'hFFFF);
        do_op(9, 0, 8'h01); do_op(9, 1, 8'h80); do_op(24, 0, 0); do_op(25, 0, 0);
        do_op(9, 0, 8'h01); do_op(9, 1, 8'h00); do_op(25, 0, 0);
        // R11 decimal adjust
        do_op(9, 0, 8'h38); do_op(0, 0, 8'h45); do_op(26, 1, 0);
        do_op(9, 0, 8'h99); do_op(0, 0, 8'h01); do_op(26, 0, 0);
        do_op(9, 0, 8'h09); do_op(0, 0, 8'h08); do_op(26, 0, 0);
        // R12 multiply
        do_op(9, 0, 8'hFF); do_op(9, 1, 8'hFF); do_op(27, 0, 0);
        do_op(9, 0, 8'h10); do_op(9, 1, 8'h08); do_op(27, 0, 0);
        do_op(9, 0, 8'h0C); do_op(9, 1, 8'h0A); do_op(27, 0, 0);
        // R13 unused codes
        do_op(30, 0, 16'hFFFF); do_op(28, 1, 0);
        // mixed sequence
        for (int i = 0; i < 400; i++) begin
            do_op(int'($urandom % 32), bit'($urandom % 2), int'($urandom % 65536));
        end
        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule